// File: doc/BRIEF.md
# Single-Error-Correcting Word Guard with Correction Flag

This block sits between a host and a word-organised storage array and protects each 32-bit data word with a Hamming code of six check bits. The write side accepts a data word, computes the check bits and presents a 38-bit codeword for storage. The read side accepts a stored codeword, forms its syndrome, repairs any one flipped bit and presents the repaired data word. A status bit records whether the most recent read needed a repair. Wear can therefore be spotted from one flag, with no readback and full-block compare.

Both data paths are valid/ready streams, and each has one register stage. An input is taken on a clock edge where its valid and ready are both high. An input ready is high whenever its output register is empty or the downstream side is taking the current output in that cycle. While an output is valid and its ready is low, the output register holds its contents unchanged. The correction flag and the uncorrectable indication are plain signals. The flag changes only on an edge where a read codeword is accepted. It takes its new value in the same cycle that the matching repaired word appears.

Top module: `word_ecc_guard`

## Requirements
- R1: `cw_out` bit p-1 holds codeword position p, for p from 1 to 38. Check bits sit at positions 1, 2, 4, 8, 16 and 32. Data bits 0 to 31 fill the other positions in ascending order, so data bit 0 is at position 3 and data bit 31 is at position 38. The check bit at position 2^k is the XOR of all data bits whose position has bit k set.
- R2: A write word accepted on an edge makes `cw_valid` high, with its codeword, from that edge onward.
- R3: A read codeword whose syndrome is zero passes its data bits through unchanged, clears `corr_flag` and leaves `rdo_uncorr` low. The syndrome is the XOR of the positions of all set codeword bits.
- R4: A read codeword with one data-position bit inverted returns the original data and sets `corr_flag`.
- R5: A read codeword with one check-position bit inverted returns the unchanged data bits and sets `corr_flag`.
- R6: A syndrome from 39 to 63 raises `rdo_uncorr`, clears `corr_flag` and passes the data bits through without modification.
- R7: The read result appears on `rdo_valid`/`rdo_data` one edge after its codeword is accepted. `corr_flag` takes its new value on that same edge.
- R8: `corr_flag` is not changed by writes or idle cycles; it changes only when a read codeword is accepted.
- R9: Each input ready equals (output not valid) OR (output ready). A stalled output keeps its valid and its data stable.
- R10: During reset and after it, both output valids and `corr_flag` are low until the first transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Write word can be taken |
| wr_data | input | 32 | Data word to encode |
| cw_valid | output | 1 | Encoded codeword available |
| cw_ready | input | 1 | Storage side takes codeword |
| cw_out | output | 38 | Encoded codeword |
| rd_valid | input | 1 | Stored codeword offered |
| rd_ready | output | 1 | Stored codeword can be taken |
| rd_cw | input | 38 | Codeword read from storage |
| rdo_valid | output | 1 | Repaired word available |
| rdo_ready | input | 1 | Host takes repaired word |
| rdo_data | output | 32 | Repaired data word |
| rdo_uncorr | output | 1 | Syndrome outside the codeword; data not repaired |
| corr_flag | output | 1 | Most recent read needed a repair |

## Verification
A wrong mapping between data bit and codeword position shows up on the first encoded word that has that bit set. It appears as a check-bit mismatch on `cw_out` one cycle after the write is accepted. A broken syndrome or flip decode repairs the wrong bit or raises the wrong flag. This shows on `rdo_data`, `corr_flag` or `rdo_uncorr` in the cycle the result becomes valid. A flag register that writes or idle cycles disturb differs from the expected value on the very next clock. Faulty stall handling shows up as a changed output or a wrong ready in the first cycle the downstream side holds ready low.

// File: rtl/word_ecc_pkg.sv
package word_ecc_pkg;

  // number of check bits needed so that every position plus "no error" is codable
  function automatic int check_bits(input int data_w);
    int p;
    p = 1;
    while ((1 << p) < data_w + p + 1) p++;
    return p;
  endfunction

  function automatic bit is_pow2(input int v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

  // 1-based codeword position of data bit idx (non-power-of-two slots, ascending)
  function automatic int slot_of(input int idx);
    int seen;
    seen = -1;
    for (int q = 1; q < 4096; q++) begin
      if (!is_pow2(q)) begin
        seen++;
        if (seen == idx) return q;
      end
    end
    return 0;
  endfunction

endpackage

// File: rtl/word_ecc_encoder.sv
module word_ecc_encoder
  import word_ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 6,
  parameter int CW_W   = DATA_W + PAR_W
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [CW_W-1:0]   cw_o
);

  function automatic logic [DATA_W-1:0] cover_mask(input int k);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = ((slot_of(i) >> k) & 1) == 1;
    return m;
  endfunction

  logic [PAR_W-1:0] par;

  for (genvar k = 0; k < PAR_W; k++) begin : g_par
    localparam logic [DATA_W-1:0] MASK = cover_mask(k);
    assign par[k] = ^(data_i & MASK);
    assign cw_o[(1 << k) - 1] = par[k];
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_data
    localparam int POS = slot_of(i);
    assign cw_o[POS-1] = data_i[i];
  end

endmodule

// File: rtl/word_ecc_decoder.sv
module word_ecc_decoder
  import word_ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PAR_W  = 6,
  parameter int CW_W   = DATA_W + PAR_W
) (
  input  logic [CW_W-1:0]   cw_i,
  output logic [DATA_W-1:0] data_o,
  output logic              corrected_o,
  output logic              uncorr_o
);

  function automatic logic [CW_W-1:0] check_mask(input int k);
    logic [CW_W-1:0] m;
    for (int p = 1; p <= CW_W; p++) m[p-1] = ((p >> k) & 1) == 1;
    return m;
  endfunction

  logic [PAR_W-1:0] syn;

  for (genvar k = 0; k < PAR_W; k++) begin : g_syn
    localparam logic [CW_W-1:0] CHK = check_mask(k);
    assign syn[k] = ^(cw_i & CHK);
  end

  // a data bit is inverted only when the syndrome names its own position
  for (genvar i = 0; i < DATA_W; i++) begin : g_fix
    localparam int POS = slot_of(i);
    assign data_o[i] = cw_i[POS-1] ^ (syn == PAR_W'(POS));
  end

  assign uncorr_o    = int'(syn) > CW_W;
  assign corrected_o = (syn != '0) && !uncorr_o;

endmodule

// File: rtl/word_ecc_slice.sv
module word_ecc_slice #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic         vld_q;
  logic [W-1:0] dat_q;

  assign in_ready  = !vld_q || out_ready;
  assign out_valid = vld_q;
  assign out_data  = dat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= in_data;
    end
  end

endmodule

// File: rtl/word_ecc_guard.sv
module word_ecc_guard
  import word_ecc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int PAR_W = check_bits(DATA_W),
  localparam int CW_W  = DATA_W + PAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cw_valid,
  input  logic              cw_ready,
  output logic [CW_W-1:0]   cw_out,
  input  logic              rd_valid,
  output logic              rd_ready,
  input  logic [CW_W-1:0]   rd_cw,
  output logic              rdo_valid,
  input  logic              rdo_ready,
  output logic [DATA_W-1:0] rdo_data,
  output logic              rdo_uncorr,
  output logic              corr_flag
);

  // write path: encode, then one register stage
  logic [CW_W-1:0] enc_cw;

  word_ecc_encoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CW_W(CW_W)) u_enc (
    .data_i (wr_data),
    .cw_o   (enc_cw)
  );

  word_ecc_slice #(.W(CW_W)) u_wr_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .in_data   (enc_cw),
    .out_valid (cw_valid),
    .out_ready (cw_ready),
    .out_data  (cw_out)
  );

  // read path: syndrome and repair, then one register stage
  logic [DATA_W-1:0] dec_data;
  logic              dec_corr;
  logic              dec_unc;
  logic [DATA_W:0]   rd_res;

  word_ecc_decoder #(.DATA_W(DATA_W), .PAR_W(PAR_W), .CW_W(CW_W)) u_dec (
    .cw_i        (rd_cw),
    .data_o      (dec_data),
    .corrected_o (dec_corr),
    .uncorr_o    (dec_unc)
  );

  word_ecc_slice #(.W(DATA_W + 1)) u_rd_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rd_valid),
    .in_ready  (rd_ready),
    .in_data   ({dec_unc, dec_data}),
    .out_valid (rdo_valid),
    .out_ready (rdo_ready),
    .out_data  (rd_res)
  );

  assign rdo_data   = rd_res[DATA_W-1:0];
  assign rdo_uncorr = rd_res[DATA_W];

  // status: loaded only when a read codeword is taken
  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                flag_q <= 1'b0;
    else if (rd_valid && rd_ready) flag_q <= dec_corr;
  end

  assign corr_flag = flag_q;

endmodule

// File: rtl/word_ecc_guard_chk.sv
module word_ecc_guard_chk #(
  parameter int CW_W = 38
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            cw_valid,
  input logic            cw_ready,
  input logic [CW_W-1:0] cw_out,
  input logic            rd_valid,
  input logic            rd_ready,
  input logic            rdo_valid,
  input logic            rdo_ready,
  input logic            rdo_uncorr,
  input logic            corr_flag
);

  assert_wr_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> cw_valid);

  assert_rd_lat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> rdo_valid);

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && rd_ready) |=> $stable(corr_flag));

  assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdo_valid |-> !(rdo_uncorr && corr_flag));

  assert_cw_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_out)));

  assert_rdo_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdo_valid && !rdo_ready) |=> (rdo_valid && $stable(rdo_uncorr)));

  assert_empty_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdo_valid |-> rd_ready) and (!cw_valid |-> wr_ready));

endmodule

bind word_ecc_guard word_ecc_guard_chk #(.CW_W(CW_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .cw_valid   (cw_valid),
  .cw_ready   (cw_ready),
  .cw_out     (cw_out),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rdo_valid  (rdo_valid),
  .rdo_ready  (rdo_ready),
  .rdo_uncorr (rdo_uncorr),
  .corr_flag  (corr_flag)
);

// File: tb/test_word_ecc_guard.sv
`timescale 1ns/1ps
module test_word_ecc_guard;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, wr_ready;
  logic [31:0] wr_data = '0;
  logic        cw_valid, cw_ready = 1'b1;
  logic [37:0] cw_out;
  logic        rd_valid = 1'b0, rd_ready;
  logic [37:0] rd_cw = '0;
  logic        rdo_valid, rdo_ready = 1'b1;
  logic [31:0] rdo_data;
  logic        rdo_uncorr, corr_flag;

  int checks = 0;
  int errors = 0;
  string tag = "R10";
  bit stall = 1'b0;
  logic [7:0] lf = 8'h5a;

  always #5 clk = ~clk;

  word_ecc_guard i_word_ecc_guard (.*);

  // ---------------- behavioural reference ----------------
  function automatic bit pw2(input int v);
    return (v & (v - 1)) == 0;
  endfunction

  function automatic logic [37:0] ref_enc(input logic [31:0] d);
    logic [37:0] c = '0;
    int j = 0;
    int s = 0;
    for (int p = 1; p <= 38; p++)
      if (!pw2(p)) begin c[p-1] = d[j]; j++; end
    for (int p = 1; p <= 38; p++) if (c[p-1]) s ^= p;
    for (int k = 0; k < 6; k++) c[(1 << k) - 1] = s[k];
    return c;
  endfunction

  // returns {uncorr, corrected, data}
  function automatic logic [33:0] ref_dec(input logic [37:0] c);
    logic [31:0] d;
    int s = 0;
    int j = 0;
    logic cr = 1'b0, un = 1'b0;
    for (int p = 1; p <= 38; p++) if (c[p-1]) s ^= p;
    if (s > 38) un = 1'b1;
    else if (s != 0) begin c[s-1] = ~c[s-1]; cr = 1'b1; end
    for (int p = 1; p <= 38; p++)
      if (!pw2(p)) begin d[j] = c[p-1]; j++; end
    return {un, cr, d};
  endfunction

  logic        m_cw_valid = 1'b0, m_rdo_valid = 1'b0, m_flag = 1'b0, m_unc = 1'b0;
  logic [37:0] m_cw = '0;
  logic [31:0] m_data = '0;
  logic        m_wr_acc = 1'b0, m_rd_acc = 1'b0;
  logic        m_wr_rdy, m_rd_rdy;

  assign m_wr_rdy = !m_cw_valid || cw_ready;
  assign m_rd_rdy = !m_rdo_valid || rdo_ready;

  always @(posedge clk) begin
    logic [33:0] r;
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    if (!rst_n) begin
      m_cw_valid <= 1'b0; m_rdo_valid <= 1'b0; m_flag <= 1'b0;
      m_wr_acc <= 1'b0; m_rd_acc <= 1'b0;
    end else begin
      m_wr_acc <= wr_valid && m_wr_rdy;
      m_rd_acc <= rd_valid && m_rd_rdy;
      if (m_wr_rdy) begin
        m_cw_valid <= wr_valid;
        if (wr_valid) m_cw <= ref_enc(wr_data);
      end
      if (m_rd_rdy) begin
        m_rdo_valid <= rd_valid;
        if (rd_valid) begin
          r = ref_dec(rd_cw);
          m_data <= r[31:0];
          m_unc  <= r[33];
          m_flag <= r[32];
        end
      end
    end
  end

  // ---------------- comparison every clock ----------------
  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk("R9", "wr_ready", 64'(wr_ready), 64'(m_wr_rdy));
    chk("R9", "rd_ready", 64'(rd_ready), 64'(m_rd_rdy));
    chk(tag == "R10" ? "R10" : "R2", "cw_valid", 64'(cw_valid), 64'(m_cw_valid));
    chk(tag == "R10" ? "R10" : "R7", "rdo_valid", 64'(rdo_valid), 64'(m_rdo_valid));
    chk(tag, "corr_flag", 64'(corr_flag), 64'(m_flag));
    if (m_cw_valid) chk("R1", "cw_out", 64'(cw_out), 64'(m_cw));
    if (m_rdo_valid) begin
      chk(tag, "rdo_data", 64'(rdo_data), 64'(m_data));
      chk(tag, "rdo_uncorr", 64'(rdo_uncorr), 64'(m_unc));
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    forever begin
      @(posedge clk); #1;
      cw_ready  = stall ? lf[0] : 1'b1;
      rdo_ready = stall ? lf[3] : 1'b1;
    end
  end

  task automatic do_write(input logic [31:0] d);
    @(posedge clk); #1;
    wr_valid = 1'b1; wr_data = d;
    do begin @(posedge clk); #2; end while (!m_wr_acc);
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [37:0] c);
    @(posedge clk); #1;
    rd_valid = 1'b1; rd_cw = c;
    do begin @(posedge clk); #2; end while (!m_rd_acc);
    rd_valid = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: progress actual 0 expected 1");
    finish_run();
  end

  logic [31:0] pats [6] = '{32'h0, 32'hffffffff, 32'ha5a5a5a5, 32'h1, 32'h80000000, 32'h12345678};

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);

    tag = "R1";
    foreach (pats[i]) do_write(pats[i]);
    do_write(32'hdeadbeef);

    tag = "R3";
    foreach (pats[i]) do_read(ref_enc(pats[i]));

    for (int p = 1; p <= 38; p++) begin
      tag = pw2(p) ? "R5" : "R4";
      do_read(ref_enc(32'h3c96_0f71) ^ (38'(1) << (p - 1)));
    end

    tag = "R6";
    do_read(ref_enc(32'h0badf00d) ^ (38'(1) << 37) ^ 38'(1));
    do_read(ref_enc(32'h77777777) ^ (38'(1) << 31) ^ (38'(1) << 30));
    do_read(ref_enc(32'h13579bdf) ^ (38'(1) << 35) ^ (38'(1) << 2));

    tag = "R8";
    do_read(ref_enc(32'hcafef00d) ^ (38'(1) << 20));
    for (int i = 0; i < 4; i++) do_write(32'h1111_0000 + i);
    repeat (3) @(posedge clk);
    do_read(ref_enc(32'hcafef00d));
    for (int i = 0; i < 3; i++) do_write(32'h2222_0000 + i);

    tag = "R9";
    stall = 1'b1;
    for (int i = 0; i < 40; i++) begin
      do_write(32'h9e3779b9 * (i + 1));
      do_read(ref_enc(32'h6a09e667 ^ i) ^ (38'(1) << (i % 38)));
    end
    stall = 1'b0;
    repeat (6) @(posedge clk);
    @(negedge clk);
    finish_run();
  end

endmodule